// File: doc/BRIEF.md
# Configurable dual/chained timer counter

This block is a timer core built around one pair of 32-bit counter words. A field in the global control register chooses how the pair is used. It can be one 64-bit up-counter, two independent 32-bit counters, or two 32-bit halves where the high half counts prescaled period events of the low half. The mode can change while the block is running. Each half has its own period value, reload value and 2-bit enable mode, and can also be held at zero by a control bit. The enable modes are off, one-shot, continuous and continuous-with-reload.

Each half picks its count clock. It can count every system clock cycle, or only those cycles where the timer input pin is high (gated). It can also count the edges of the timer input pin, with an optional inversion so that falling edges count. The pin is synchronized into the system clock domain, so every count change happens on the system clock.

A simple write/read register port sets the configuration and reads back the counters and status. The block drives a one-cycle event per half when that half matches its period, and a separate event when the 64-bit counter matches.

Top module: `split_timer`

## Requirements
- R1: After reset, the global control, both half configurations, counters, periods, reloads and status all read 0, so the block starts in 64-bit mode.
- R2: Global control register (address 0) layout: bits [1:0] select the mode. 0 is 64-bit, 1 is two unchained halves and 3 is prescaler-chained halves. Value 2 is a parked mode in which neither counter word changes except by a register write or hold.
- R3: A half whose enable field is 0 keeps its count unchanged.
- R4: Enable value 1 is one-shot. When the count equals the period and a count occurs, the half stops with the count equal to the period and emits one event. It clears its run status bit (status address 9, bit 0 low half, bit 1 high half). Writing the half's configuration register re-arms it.
- R5: Enable value 2 is continuous. A count occurring while count equals period wraps the count to 0 and emits a one-cycle event.
- R6: Enable value 3 is continuous-with-reload. A count occurring while count equals period loads that half's reload register and emits an event.
- R7: In chained mode, the high half advances only when a low-half period event arrives while the 8-bit prescale counter equals the prescale setting (global control bits [15:8]). Otherwise that event increments the prescale counter, which then returns to 0 after firing. The prescale counter reads at status bits [15:8].
- R8: With the pin-source bit set (configuration bit 2), a half counts once per rising edge of the synchronized timer input. With the invert bit also set (bit 4), it counts once per falling edge instead.
- R9: With the internal source selected, setting the gate bit (bit 3) makes a half count only on cycles where the synchronized input is high. The gate bit has no effect when the pin is the source.
- R10: While a half's hold bit is set (global control bit 4 low, bit 5 high), its counter reads 0, ignores counter writes and reports run status 0.
- R11: In 64-bit mode the low half's configuration drives the pair as one counter {high,low}. A carry out of the low word advances the high word in the same cycle. A match with {period high, period low} emits only the wide event, never the per-half events.
- R12: Registers read back what was written. The half configurations are at addresses 1 (low) and 2 (high), with the enable mode in bits [1:0]. Counters are at 3 and 4, periods at 5 and 6, and reloads at 7 and 8. A counter write replaces the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tin | input | 1 | Asynchronous timer input pin |
| evt_lo | output | 1 | Low half period event |
| evt_hi | output | 1 | High half period event |
| evt_wide | output | 1 | 64-bit period event |

## Verification
The hardest situation to reach is a high-half advance in chained mode. It needs a whole train of low-half period events with the prescale counter landing exactly on its setting, and a count from free-running clocks would make the expected values depend on exact cycle timing. The stimulus therefore clocks the low half from the input pin, with a period of 1 and a prescale setting of 2. A known number of pin pulses then gives a known number of low events, high advances and a known prescale residue. The continuous and reload cases use the internal clock between two register writes that are a fixed number of cycles apart, so the bench can work out the count and the event total exactly.

// File: rtl/stmr_pkg.sv
package stmr_pkg;

    localparam int WORD_W   = 32;
    localparam int WIDE_W   = 2 * WORD_W;
    localparam int PSC_W    = 8;
    localparam int ADDR_W   = 4;
    localparam int N_HALVES = 2;

    // register addresses
    localparam int A_GCTRL  = 0;
    localparam int A_CFG_LO = 1;
    localparam int A_CNT_LO = 3;
    localparam int A_PRD_LO = 5;
    localparam int A_REL_LO = 7;
    localparam int A_STAT   = 9;

    // global control / status field positions
    localparam int HOLD_LSB = 4;
    localparam int PSC_LSB  = 8;

    typedef enum logic [1:0] {
        MODE_WIDE  = 2'd0,
        MODE_SPLIT = 2'd1,
        MODE_PARK  = 2'd2,
        MODE_CHAIN = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ENA_OFF    = 2'd0,
        ENA_ONCE   = 2'd1,
        ENA_LOOP   = 2'd2,
        ENA_RELOAD = 2'd3
    } tmr_ena_e;

    typedef struct packed {
        logic     invert;
        logic     gate;
        logic     pin_src;
        tmr_ena_e ena;
    } half_cfg_t;

    function automatic half_cfg_t unpack_cfg(input logic [WORD_W-1:0] d);
        half_cfg_t c;
        c.ena     = tmr_ena_e'(d[1:0]);
        c.pin_src = d[2];
        c.gate    = d[3];
        c.invert  = d[4];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cfg(input half_cfg_t c);
        logic [WORD_W-1:0] d;
        d      = '0;
        d[1:0] = c.ena;
        d[2]   = c.pin_src;
        d[3]   = c.gate;
        d[4]   = c.invert;
        return d;
    endfunction

    // value a counter takes when it advances
    function automatic logic [WIDE_W-1:0] advance_val(
        input logic [WIDE_W-1:0] c,
        input logic [WIDE_W-1:0] p,
        input logic [WIDE_W-1:0] r,
        input tmr_ena_e          e
    );
        if (c != p) return c + WIDE_W'(1);
        case (e)
            ENA_RELOAD: return r;
            ENA_ONCE:   return c;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/stmr_regs.sv
module stmr_regs
    import stmr_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [WORD_W-1:0]                    wr_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [WORD_W-1:0]                    rd_data,
    output tmr_mode_e                            mode,
    output logic [PSC_W-1:0]                     psc_prd,
    output logic [N_HALVES-1:0]                  hold,
    output half_cfg_t [N_HALVES-1:0]             cfg,
    output logic [N_HALVES-1:0][WORD_W-1:0]      prd,
    output logic [N_HALVES-1:0][WORD_W-1:0]      rel,
    output logic [N_HALVES-1:0]                  cfg_we,
    output logic [N_HALVES-1:0]                  cnt_we,
    input  logic [N_HALVES-1:0][WORD_W-1:0]      cnt,
    input  logic [N_HALVES-1:0]                  run,
    input  logic [PSC_W-1:0]                     psc_cnt
);

    tmr_mode_e                        mode_q;
    logic [PSC_W-1:0]                 psc_prd_q;
    logic [N_HALVES-1:0]              hold_q;
    half_cfg_t [N_HALVES-1:0]         cfg_q;
    logic [N_HALVES-1:0][WORD_W-1:0]  prd_q;
    logic [N_HALVES-1:0][WORD_W-1:0]  rel_q;
    logic [N_HALVES-1:0]              prd_we;
    logic [N_HALVES-1:0]              rel_we;
    logic                             gctrl_we;

    always_comb begin
        gctrl_we = wr_en && (int'(wr_addr) == A_GCTRL);
        for (int h = 0; h < N_HALVES; h++) begin
            cfg_we[h] = wr_en && (int'(wr_addr) == A_CFG_LO + h);
            cnt_we[h] = wr_en && (int'(wr_addr) == A_CNT_LO + h);
            prd_we[h] = wr_en && (int'(wr_addr) == A_PRD_LO + h);
            rel_we[h] = wr_en && (int'(wr_addr) == A_REL_LO + h);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_WIDE;
            psc_prd_q <= '0;
            hold_q    <= '0;
            cfg_q     <= '0;
            prd_q     <= '0;
            rel_q     <= '0;
        end else begin
            if (gctrl_we) begin
                mode_q    <= tmr_mode_e'(wr_data[1:0]);
                hold_q    <= wr_data[HOLD_LSB +: N_HALVES];
                psc_prd_q <= wr_data[PSC_LSB +: PSC_W];
            end
            for (int h = 0; h < N_HALVES; h++) begin
                if (cfg_we[h]) cfg_q[h] <= unpack_cfg(wr_data);
                if (prd_we[h]) prd_q[h] <= wr_data;
                if (rel_we[h]) rel_q[h] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (int'(rd_addr))
            A_GCTRL: begin
                rd_data[1:0]                 = mode_q;
                rd_data[HOLD_LSB +: N_HALVES] = hold_q;
                rd_data[PSC_LSB +: PSC_W]     = psc_prd_q;
            end
            A_CFG_LO:     rd_data = pack_cfg(cfg_q[0]);
            A_CFG_LO + 1: rd_data = pack_cfg(cfg_q[1]);
            A_CNT_LO:     rd_data = cnt[0];
            A_CNT_LO + 1: rd_data = cnt[1];
            A_PRD_LO:     rd_data = prd_q[0];
            A_PRD_LO + 1: rd_data = prd_q[1];
            A_REL_LO:     rd_data = rel_q[0];
            A_REL_LO + 1: rd_data = rel_q[1];
            A_STAT: begin
                rd_data[N_HALVES-1:0]     = run;
                rd_data[PSC_LSB +: PSC_W] = psc_cnt;
            end
            default: rd_data = '0;
        endcase
    end

    assign mode    = mode_q;
    assign psc_prd = psc_prd_q;
    assign hold    = hold_q;
    assign cfg     = cfg_q;
    assign prd     = prd_q;
    assign rel     = rel_q;

    AST_CFG_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        cfg_we[0] |=> (cfg_q[0].ena == tmr_ena_e'($past(wr_data[1:0])))); // R12

endmodule

// File: rtl/stmr_tick.sv
module stmr_tick
    import stmr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tin,
    input  half_cfg_t [N_HALVES-1:0] cfg,
    output logic [N_HALVES-1:0]      tick
);

    logic sync1_q;
    logic sync2_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= tin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    generate
        for (genvar g = 0; g < N_HALVES; g++) begin : g_half
            logic edge_hit;

            always_comb begin
                edge_hit = cfg[g].invert ? (!sync2_q && prev_q) : (sync2_q && !prev_q);
                tick[g]  = cfg[g].pin_src ? edge_hit : (!cfg[g].gate || sync2_q);
            end

            AST_PIN_SINGLE_TICK: assert property (@(posedge clk) disable iff (rst)
                (tick[g] && cfg[g].pin_src) |=> !(tick[g] && cfg[g].pin_src)); // R8

            AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
                (!cfg[g].pin_src && cfg[g].gate && !$past(tin, 2)) |-> !tick[g]); // R9
        end
    endgenerate

endmodule

// File: rtl/stmr_count.sv
module stmr_count
    import stmr_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  tmr_mode_e                        mode,
    input  half_cfg_t [N_HALVES-1:0]         cfg,
    input  logic [N_HALVES-1:0][WORD_W-1:0]  prd,
    input  logic [N_HALVES-1:0][WORD_W-1:0]  rel,
    input  logic [PSC_W-1:0]                 psc_prd,
    input  logic [N_HALVES-1:0]              hold,
    input  logic [N_HALVES-1:0]              tick,
    input  logic [N_HALVES-1:0]              cnt_we,
    input  logic [N_HALVES-1:0]              cfg_we,
    input  logic [WORD_W-1:0]                cnt_wdata,
    output logic [N_HALVES-1:0][WORD_W-1:0]  cnt,
    output logic [N_HALVES-1:0]              run,
    output logic [PSC_W-1:0]                 psc_cnt,
    output logic [N_HALVES-1:0]              evt_half,
    output logic                             evt_wide
);

    logic [N_HALVES-1:0][WORD_W-1:0]  cnt_q;
    logic [N_HALVES-1:0]              done_q;
    logic [PSC_W-1:0]                 psc_q;
    logic [N_HALVES-1:0]              evt_half_q;
    logic                             evt_wide_q;

    logic [WIDE_W-1:0]                wide_cnt;
    logic [WIDE_W-1:0]                wide_prd;
    logic [WIDE_W-1:0]                wide_rel;
    logic [WIDE_W-1:0]                wide_next;
    logic                             wide_adv;
    logic                             wide_match;
    logic [N_HALVES-1:0][WIDE_W-1:0]  half_full;
    logic [N_HALVES-1:0]              half_match;
    logic [N_HALVES-1:0]              split_adv;
    logic [N_HALVES-1:0]              half_evt;
    logic [N_HALVES-1:0]              once_done;
    logic                             psc_fire;
    logic                             split_mode;

    always_comb begin
        for (int h = 0; h < N_HALVES; h++)
            run[h] = (cfg[h].ena != ENA_OFF) && !done_q[h] && !hold[h];
    end

    // one 64-bit counter
    always_comb begin
        wide_cnt   = {cnt_q[1], cnt_q[0]};
        wide_prd   = {prd[1], prd[0]};
        wide_rel   = {rel[1], rel[0]};
        wide_adv   = (mode == MODE_WIDE) && run[0] && tick[0];
        wide_match = (wide_cnt == wide_prd);
        wide_next  = advance_val(wide_cnt, wide_prd, wide_rel, cfg[0].ena);
    end

    // two halves, free or chained through the prescaler
    always_comb begin
        split_mode = (mode == MODE_SPLIT) || (mode == MODE_CHAIN);
        for (int h = 0; h < N_HALVES; h++) begin
            half_full[h]  = advance_val({{WORD_W{1'b0}}, cnt_q[h]},
                                        {{WORD_W{1'b0}}, prd[h]},
                                        {{WORD_W{1'b0}}, rel[h]},
                                        cfg[h].ena);
            half_match[h] = (cnt_q[h] == prd[h]);
        end
        split_adv[0] = split_mode && run[0] && tick[0];
        half_evt[0]  = split_adv[0] && half_match[0];
        psc_fire     = (mode == MODE_CHAIN) && half_evt[0] && (psc_q == psc_prd);
        split_adv[1] = run[1] && (((mode == MODE_SPLIT) && tick[1]) || psc_fire);
        half_evt[1]  = split_adv[1] && half_match[1];
        once_done[0] = (wide_adv && wide_match && (cfg[0].ena == ENA_ONCE)) ||
                       (half_evt[0] && (cfg[0].ena == ENA_ONCE));
        once_done[1] = half_evt[1] && (cfg[1].ena == ENA_ONCE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            done_q     <= '0;
            evt_half_q <= '0;
            evt_wide_q <= 1'b0;
        end else begin
            for (int h = 0; h < N_HALVES; h++) begin
                if (hold[h])
                    cnt_q[h] <= '0;
                else if (cnt_we[h])
                    cnt_q[h] <= cnt_wdata;
                else if (wide_adv)
                    cnt_q[h] <= wide_next[h*WORD_W +: WORD_W];
                else if (split_adv[h])
                    cnt_q[h] <= half_full[h][WORD_W-1:0];

                if (cfg_we[h])
                    done_q[h] <= 1'b0;
                else if (once_done[h])
                    done_q[h] <= 1'b1;
            end
            evt_half_q <= half_evt;
            evt_wide_q <= wide_adv && wide_match;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold[1] || (mode != MODE_CHAIN))
            psc_q <= '0;
        else if (half_evt[0])
            psc_q <= psc_fire ? '0 : psc_q + PSC_W'(1);
    end

    assign cnt      = cnt_q;
    assign psc_cnt  = psc_q;
    assign evt_half = evt_half_q;
    assign evt_wide = evt_wide_q;

    AST_PARK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PARK && hold == '0 && cnt_we == '0)
        |=> ($stable(cnt_q[0]) && $stable(cnt_q[1]))); // R2

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg[0].ena == ENA_OFF && !hold[0] && !cnt_we[0]) |=> $stable(cnt_q[0])); // R3

    AST_ONCE_PARKS: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_q[0]) && !$past(cnt_we[0])) |-> (cnt_q[0] == $past(prd[0]))); // R4

    AST_CHAIN_GATED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAIN && !half_evt[0] && !hold[1] && !cnt_we[1])
        |=> $stable(cnt_q[1])); // R7

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        hold[1] |=> (cnt_q[1] == '0)); // R10

    AST_WIDE_NO_HALF_EVT: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE) |=> (evt_half_q == '0)); // R11

endmodule

// File: rtl/split_timer.sv
module split_timer
    import stmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tin,
    output logic              evt_lo,
    output logic              evt_hi,
    output logic              evt_wide
);

    tmr_mode_e                        mode;
    logic [PSC_W-1:0]                 psc_prd;
    logic [PSC_W-1:0]                 psc_cnt;
    logic [N_HALVES-1:0]              hold;
    half_cfg_t [N_HALVES-1:0]         cfg;
    logic [N_HALVES-1:0][WORD_W-1:0]  prd;
    logic [N_HALVES-1:0][WORD_W-1:0]  rel;
    logic [N_HALVES-1:0][WORD_W-1:0]  cnt;
    logic [N_HALVES-1:0]              cfg_we;
    logic [N_HALVES-1:0]              cnt_we;
    logic [N_HALVES-1:0]              run;
    logic [N_HALVES-1:0]              tick;
    logic [N_HALVES-1:0]              evt_half;

    stmr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .mode    (mode),
        .psc_prd (psc_prd),
        .hold    (hold),
        .cfg     (cfg),
        .prd     (prd),
        .rel     (rel),
        .cfg_we  (cfg_we),
        .cnt_we  (cnt_we),
        .cnt     (cnt),
        .run     (run),
        .psc_cnt (psc_cnt)
    );

    stmr_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .tin  (tin),
        .cfg  (cfg),
        .tick (tick)
    );

    stmr_count u_count (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cfg       (cfg),
        .prd       (prd),
        .rel       (rel),
        .psc_prd   (psc_prd),
        .hold      (hold),
        .tick      (tick),
        .cnt_we    (cnt_we),
        .cfg_we    (cfg_we),
        .cnt_wdata (wr_data),
        .cnt       (cnt),
        .run       (run),
        .psc_cnt   (psc_cnt),
        .evt_half  (evt_half),
        .evt_wide  (evt_wide)
    );

    assign evt_lo = evt_half[0];
    assign evt_hi = evt_half[1];

endmodule

// File: tb/tb_split_timer.sv
module tb_split_timer;
    import stmr_pkg::*;

    localparam int C_PIN  = 4;
    localparam int C_GATE = 8;
    localparam int C_INV  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [WORD_W-1:0] rd_data;
    logic              tin = 1'b0;
    logic              evt_lo, evt_hi, evt_wide;

    int total = 0;
    int bad   = 0;
    int n_lo = 0, n_hi = 0, n_wide = 0;

    typedef struct {
        int          addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    split_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tin(tin),
        .evt_lo(evt_lo), .evt_hi(evt_hi), .evt_wide(evt_wide)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (evt_lo)   n_lo++;
            if (evt_hi)   n_hi++;
            if (evt_wide) n_wide++;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected register values and compares with the read port
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                rd_addr = ADDR_W'(it.addr);
                #1;
                check(rd_data == it.exp, it.tag, longint'(rd_data), longint'(it.exp));
            end
        end
    end

    // driver side
    task automatic expect_reg(input int addr, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.addr = addr;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tin = 1'b1;
            repeat (3) @(negedge clk);
            tin = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // requirement model: k advances from zero, continuous or reload
    function automatic void model(input int unsigned p, input int unsigned r, input bit reload,
                                  input int k, output int unsigned c, output int e);
        c = 0;
        e = 0;
        for (int i = 0; i < k; i++) begin
            if (c == p) begin
                c = reload ? r : 0;
                e++;
            end else begin
                c++;
            end
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned mc;
        int me;
        int base;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_reg(A_GCTRL, 32'h0, "R1 gctrl after reset");
        expect_reg(A_CFG_LO, 32'h0, "R1 cfg lo after reset");
        expect_reg(A_CNT_LO, 32'h0, "R1 cnt lo after reset");
        expect_reg(A_CNT_LO + 1, 32'h0, "R1 cnt hi after reset");
        expect_reg(A_STAT, 32'h0, "R1 status after reset");

        // R12 read-back
        wr(A_PRD_LO + 1, 32'h1234);
        expect_reg(A_PRD_LO + 1, 32'h1234, "R12 period hi readback");
        wr(A_CNT_LO + 1, 32'hABCD);
        expect_reg(A_CNT_LO + 1, 32'hABCD, "R12 counter write");
        wr(A_CFG_LO + 1, 32'h1D);
        expect_reg(A_CFG_LO + 1, 32'h1D, "R12 cfg hi readback");
        wr(A_CFG_LO + 1, 32'h0);

        // R5 continuous in split mode, K = 22 advances
        wr(A_GCTRL, 1);
        wr(A_PRD_LO, 4);
        wr(A_CNT_LO, 0);
        base = n_lo;
        wr(A_CFG_LO, 2);
        repeat (20) @(negedge clk);
        wr(A_CFG_LO, 0);
        settle();
        model(4, 0, 1'b0, 22, mc, me);
        expect_reg(A_CNT_LO, mc, "R5 continuous count");
        check(n_lo - base == me, "R5 continuous events", n_lo - base, me);
        expect_reg(A_CNT_LO + 1, 32'hABCD, "R3 disabled hi half holds");

        // R6 reload
        wr(A_REL_LO, 2);
        wr(A_CNT_LO, 0);
        base = n_lo;
        wr(A_CFG_LO, 3);
        repeat (20) @(negedge clk);
        wr(A_CFG_LO, 0);
        settle();
        model(4, 2, 1'b1, 22, mc, me);
        expect_reg(A_CNT_LO, mc, "R6 reload count");
        check(n_lo - base == me, "R6 reload events", n_lo - base, me);

        // R4 one-shot
        wr(A_PRD_LO, 10);
        wr(A_CNT_LO, 0);
        base = n_lo;
        wr(A_CFG_LO, 1);
        expect_reg(A_STAT, 32'h1, "R4 run status while counting");
        repeat (30) @(negedge clk);
        expect_reg(A_CNT_LO, 10, "R4 one-shot parks at period");
        expect_reg(A_STAT, 32'h0, "R4 run status cleared");
        check(n_lo - base == 1, "R4 one-shot single event", n_lo - base, 1);
        wr(A_CNT_LO, 0);
        wr(A_CFG_LO, 1);
        repeat (30) @(negedge clk);
        expect_reg(A_CNT_LO, 10, "R4 re-armed one-shot");
        check(n_lo - base == 2, "R4 re-armed event", n_lo - base, 2);
        wr(A_CFG_LO, 0);

        // R8 pin clock on high half
        wr(A_CNT_LO + 1, 0);
        wr(A_PRD_LO + 1, 100);
        wr(A_CFG_LO + 1, 2 | C_PIN);
        pulse(5);
        settle();
        expect_reg(A_CNT_LO + 1, 5, "R8 rising edges counted");
        wr(A_CFG_LO + 1, 2 | C_PIN | C_INV);
        tin = 1'b1;
        repeat (6) @(negedge clk);
        expect_reg(A_CNT_LO + 1, 5, "R8 inverted ignores rise");
        tin = 1'b0;
        settle();
        expect_reg(A_CNT_LO + 1, 6, "R8 inverted counts fall");

        // R9 gate has no effect on pin source
        wr(A_CFG_LO + 1, 2 | C_PIN | C_GATE);
        tin = 1'b1;
        repeat (10) @(negedge clk);
        tin = 1'b0;
        settle();
        expect_reg(A_CNT_LO + 1, 7, "R9 gate ignored for pin source");

        // R9 gated internal clock
        wr(A_CFG_LO + 1, 0);
        wr(A_CNT_LO + 1, 0);
        wr(A_CFG_LO + 1, 2 | C_GATE);
        repeat (10) @(negedge clk);
        expect_reg(A_CNT_LO + 1, 0, "R9 gate closed while input low");
        @(negedge clk);
        tin = 1'b1;
        repeat (7) @(negedge clk);
        tin = 1'b0;
        settle();
        expect_reg(A_CNT_LO + 1, 7, "R9 counts only high cycles");
        wr(A_CFG_LO + 1, 0);

        // R10 hold
        wr(A_GCTRL, 1 | (1 << HOLD_LSB));
        wr(A_CNT_LO, 55);
        wr(A_CFG_LO, 2);
        repeat (5) @(negedge clk);
        expect_reg(A_CNT_LO, 0, "R10 held counter reads zero");
        expect_reg(A_STAT, 32'h0, "R10 held half not running");
        wr(A_CFG_LO, 0);
        wr(A_GCTRL, 1);
        wr(A_CNT_LO, 9);
        expect_reg(A_CNT_LO, 9, "R10 released counter writable");

        // R2 parked mode
        wr(A_GCTRL, 2);
        wr(A_CNT_LO, 3);
        wr(A_CFG_LO, 2);
        repeat (20) @(negedge clk);
        expect_reg(A_CNT_LO, 3, "R2 parked mode frozen");
        wr(A_CFG_LO, 0);

        // R11 64-bit carry and wide event
        wr(A_GCTRL, 0);
        wr(A_CNT_LO, 32'hFFFF_FFFE);
        wr(A_CNT_LO + 1, 0);
        wr(A_PRD_LO + 1, 1);
        wr(A_PRD_LO, 2);
        base = n_lo + n_hi;
        me = n_wide;
        wr(A_CFG_LO, 2 | C_PIN);
        pulse(2);
        settle();
        expect_reg(A_CNT_LO, 0, "R11 low word after carry");
        expect_reg(A_CNT_LO + 1, 1, "R11 carry into high word");
        pulse(3);
        settle();
        expect_reg(A_CNT_LO, 0, "R11 wide wrap low");
        expect_reg(A_CNT_LO + 1, 0, "R11 wide wrap high");
        check(n_wide - me == 1, "R11 one wide event", n_wide - me, 1);
        check(n_lo + n_hi - base == 0, "R11 no half events in wide mode", n_lo + n_hi - base, 0);
        wr(A_CFG_LO, 0);

        // R7 chained with prescale 2
        wr(A_GCTRL, 3 | (2 << PSC_LSB));
        wr(A_CNT_LO, 0);
        wr(A_CNT_LO + 1, 0);
        wr(A_PRD_LO, 1);
        wr(A_PRD_LO + 1, 100);
        wr(A_CFG_LO + 1, 2);
        repeat (10) @(negedge clk);
        expect_reg(A_CNT_LO + 1, 0, "R7 high idle without low events");
        base = n_lo;
        wr(A_CFG_LO, 2 | C_PIN);
        pulse(12);
        settle();
        check(n_lo - base == 6, "R7 low events", n_lo - base, 6);
        expect_reg(A_CNT_LO, 0, "R7 low count");
        expect_reg(A_CNT_LO + 1, 2, "R7 high advanced per prescale");
        expect_reg(A_STAT, 32'h3, "R7 status prescale residue zero");
        pulse(2);
        settle();
        expect_reg(A_STAT, 32'h103, "R7 prescale counter one");
        expect_reg(A_CNT_LO + 1, 2, "R7 high waits for prescale");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule